// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer with Wall Clock

This peripheral sits on a simple register bus and combines three time functions. A periodic interrupt timer counts a 32-bit throttle value down once per bus period. When the count runs out it raises an interrupt request that carries a software-chosen interrupt number, with a 4-bit priority field ORed into bits 2 to 5 of that number. A free-running wall clock keeps a 64-bit seconds count and a 32-bit nanoseconds count. Each clock cycle it adds the programmed bus period, in nanoseconds, to the nanoseconds count and carries into the seconds count once per second. A separate 12-bit countdown counter runs down to zero after software loads it.

Software programs the bus period to the real length of one clock cycle and picks the interrupt period as a throttle count. It then enables the timer and acknowledges each interrupt by returning its number on the acknowledge port. Reading the seconds low word captures the seconds high word and the nanoseconds into a snapshot, so a read of the low word followed by reads of the high word and the nanoseconds gives a consistent timestamp.

Top module: `ptmr_top`

## Requirements
- R1: After reset the bus period register reads 4, every other register reads 0, and irq_req is low.
- R2: A read presents its data on bus_rdata one cycle after the read strobe. The control register (offset 0x00) reads back only bits 0, 7:4 and 15:8. Throttle (0x10) and bus period (0x18) read back as written. An unmapped offset reads 0.
- R3: When no time register is written in a cycle, the nanoseconds count (0x28) adds the bus period. If the sum reaches 1,000,000,000, that amount is subtracted and the seconds count increments in the same cycle.
- R4: The seconds count is 64 bits wide, with the high word at 0x20 and the low word at 0x24. A carry out of the low word increments the high word.
- R5: A read of 0x24 returns the live seconds low word and captures the live seconds high word and nanoseconds. Later reads of 0x20 and 0x28 return the captured values until the next read of 0x24.
- R6: A write to 0x20, 0x24 or 0x28 loads that field, and the clock does not advance in that cycle.
- R7: A write to the control register that sets bit 0 while the timer is stopped loads the throttle value. irq_req then rises exactly throttle cycles after the write, and again every throttle cycles after that. A throttle of 0 behaves as 1.
- R8: irq_num equals the interrupt-number field (control bits 15:8) ORed with the priority field (control bits 7:4) shifted left by 2.
- R9: A raised request stays high until irq_ack is asserted with irq_ack_num equal to irq_num. An acknowledge with any other number is ignored, and a new expiry in the same cycle as a matching acknowledge keeps the request high.
- R10: A control write with bit 0 clear drops irq_req in the same edge and stops the periodic count.
- R11: A write to 0x14 loads the low 12 bits of the data into the countdown counter. The counter then decrements once per cycle while it is non-zero and holds at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one bus period |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_req | output | 1 | Interrupt request, held until acknowledged |
| irq_num | output | 8 | Interrupt number with priority merged in |
| irq_ack | input | 1 | Acknowledge strobe |
| irq_ack_num | input | 8 | Number being acknowledged |

## Verification
The bench drives the nanoseconds count just below one second and the seconds low word to all ones. This exposes a carry that is lost or comes one cycle late, and a high word that never moves. It writes the nanoseconds and then reads it back through the snapshot path: a design that advances in the write cycle, or latches after rather than at the low-word read, returns a different value. The periodic timer is timed from the enabling write to the rise of the request, both for the first period and for the next one. An off-by-one reload shows up as a period of throttle plus or minus one. Wrong-number acknowledges, an acknowledge colliding with a throttle-0 expiry, a disable with a request pending and a countdown left long enough to hit zero all catch designs that drop, keep or wrap the wrong state.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  localparam logic [31:0] NS_PER_SEC = 32'd1_000_000_000;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_THROT  = 8'h10;
  localparam logic [7:0] OFS_CDOWN  = 8'h14;
  localparam logic [7:0] OFS_BUSPER = 8'h18;
  localparam logic [7:0] OFS_SEC_HI = 8'h20;
  localparam logic [7:0] OFS_SEC_LO = 8'h24;
  localparam logic [7:0] OFS_NSEC   = 8'h28;

  // Returns {second_carry, next_nanoseconds}
  function automatic logic [32:0] ns_advance(input logic [31:0] cur, input logic [31:0] inc);
    logic [32:0] sum;
    logic [32:0] wrapped;
    sum     = {1'b0, cur} + {1'b0, inc};
    wrapped = sum - {1'b0, NS_PER_SEC};
    if (sum >= {1'b0, NS_PER_SEC}) return {1'b1, wrapped[31:0]};
    return {1'b0, sum[31:0]};
  endfunction

endpackage

// File: rtl/ptmr_wallclk.sv
module ptmr_wallclk import ptmr_pkg::*; #(
  parameter int SEC_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      bus_period,
  input  logic             ld_hi,
  input  logic             ld_lo,
  input  logic             ld_ns,
  input  logic [31:0]      ld_data,
  output logic [SEC_W-1:0] sec_q,
  output logic [31:0]      ns_q,
  output logic             roll
);
  localparam int HI_W = SEC_W - 32;

  logic        ld_any;
  logic [32:0] step;

  assign ld_any = ld_hi | ld_lo | ld_ns;
  assign step   = ns_advance(ns_q, bus_period);
  assign roll   = step[32] & ~ld_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else if (ld_any) begin
      if (ld_hi) sec_q[SEC_W-1:32] <= HI_W'(ld_data);
      if (ld_lo) sec_q[31:0]       <= ld_data;
      if (ld_ns) ns_q              <= ld_data;
    end else begin
      ns_q <= step[31:0];
      if (step[32]) sec_q <= sec_q + SEC_W'(1);
    end
  end
endmodule

// File: rtl/ptmr_periodic.sv
module ptmr_periodic #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             arm,
  input  logic             disarm,
  input  logic             ack_hit,
  input  logic [CNT_W-1:0] reload,
  output logic             irq_req,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_eff;

  assign reload_eff = (reload == '0) ? CNT_W'(1) : reload;
  assign expire     = en & ~disarm & (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      irq_req <= 1'b0;
    end else begin
      if (arm)
        cnt_q <= reload_eff;
      else if (en && !disarm)
        cnt_q <= expire ? reload_eff : cnt_q - CNT_W'(1);

      if (disarm || !en) irq_req <= 1'b0;
      else if (expire)   irq_req <= 1'b1;
      else if (ack_hit)  irq_req <= 1'b0;
    end
  end
endmodule

// File: rtl/ptmr_cdown.sv
module ptmr_cdown #(
  parameter int CD_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld,
  input  logic [CD_W-1:0] ld_val,
  output logic [CD_W-1:0] cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (ld)             cnt_q <= ld_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CD_W'(1);
  end
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top import ptmr_pkg::*; #(
  parameter int          CD_W     = 12,
  parameter int          SEC_W    = 64,
  parameter int          IRQ_W    = 8,
  parameter int          PRIO_W   = 4,
  parameter int          THR_W    = 32,
  parameter logic [31:0] BP_RESET = 32'd4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq_req,
  output logic [IRQ_W-1:0] irq_num,
  input  logic             irq_ack,
  input  logic [IRQ_W-1:0] irq_ack_num
);
  localparam int PRIO_LSB = 4;
  localparam int NUM_LSB  = PRIO_LSB + PRIO_W;
  localparam int HI_W     = SEC_W - 32;

  function automatic logic [IRQ_W-1:0] merge_irq(input logic [IRQ_W-1:0] num,
                                                 input logic [PRIO_W-1:0] prio);
    return num | (IRQ_W'(prio) << 2);
  endfunction

  logic              en_q;
  logic [PRIO_W-1:0] prio_q;
  logic [IRQ_W-1:0]  num_q;
  logic [THR_W-1:0]  throt_q;
  logic [31:0]       bp_q;
  logic [HI_W-1:0]   snap_hi_q;
  logic [31:0]       snap_ns_q;
  logic [31:0]       rdata_q;

  logic [SEC_W-1:0]  sec_q;
  logic [31:0]       ns_q;
  logic              roll;
  logic [CD_W-1:0]   cd_q;
  logic              expire;

  logic ctrl_wr, throt_wr, cd_wr, bp_wr, hi_wr, lo_wr, ns_wr, time_wr;
  logic arm, disarm, ack_hit;

  assign ctrl_wr  = bus_wr && (bus_addr == OFS_CTRL);
  assign throt_wr = bus_wr && (bus_addr == OFS_THROT);
  assign cd_wr    = bus_wr && (bus_addr == OFS_CDOWN);
  assign bp_wr    = bus_wr && (bus_addr == OFS_BUSPER);
  assign hi_wr    = bus_wr && (bus_addr == OFS_SEC_HI);
  assign lo_wr    = bus_wr && (bus_addr == OFS_SEC_LO);
  assign ns_wr    = bus_wr && (bus_addr == OFS_NSEC);
  assign time_wr  = hi_wr | lo_wr | ns_wr;

  assign arm      = ctrl_wr & bus_wdata[0] & ~en_q;
  assign disarm   = ctrl_wr & ~bus_wdata[0];
  assign irq_num  = merge_irq(num_q, prio_q);
  assign ack_hit  = irq_ack && (irq_ack_num == irq_num);
  assign bus_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      prio_q  <= '0;
      num_q   <= '0;
      throt_q <= '0;
      bp_q    <= BP_RESET;
    end else begin
      if (ctrl_wr) begin
        en_q   <= bus_wdata[0];
        prio_q <= bus_wdata[PRIO_LSB +: PRIO_W];
        num_q  <= bus_wdata[NUM_LSB +: IRQ_W];
      end
      if (throt_wr) throt_q <= bus_wdata[THR_W-1:0];
      if (bp_wr)    bp_q    <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q   <= '0;
      snap_hi_q <= '0;
      snap_ns_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_CTRL:   rdata_q <= 32'({num_q, prio_q, 3'b000, en_q});
        OFS_THROT:  rdata_q <= 32'(throt_q);
        OFS_CDOWN:  rdata_q <= 32'(cd_q);
        OFS_BUSPER: rdata_q <= bp_q;
        OFS_SEC_HI: rdata_q <= 32'(snap_hi_q);
        OFS_SEC_LO: begin
          rdata_q   <= sec_q[31:0];
          snap_hi_q <= sec_q[SEC_W-1:32];
          snap_ns_q <= ns_q;
        end
        OFS_NSEC:   rdata_q <= snap_ns_q;
        default:    rdata_q <= '0;
      endcase
    end
  end

  ptmr_wallclk #(.SEC_W(SEC_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .bus_period(bp_q),
    .ld_hi(hi_wr), .ld_lo(lo_wr), .ld_ns(ns_wr), .ld_data(bus_wdata),
    .sec_q(sec_q), .ns_q(ns_q), .roll(roll)
  );

  ptmr_periodic #(.CNT_W(THR_W)) u_per (
    .clk(clk), .rst_n(rst_n), .en(en_q), .arm(arm), .disarm(disarm),
    .ack_hit(ack_hit), .reload(throt_q), .irq_req(irq_req), .expire(expire)
  );

  ptmr_cdown #(.CD_W(CD_W)) u_cd (
    .clk(clk), .rst_n(rst_n), .ld(cd_wr), .ld_val(bus_wdata[CD_W-1:0]), .cnt_q(cd_q)
  );
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk import ptmr_pkg::*; #(
  parameter int SEC_W = 64,
  parameter int CD_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEC_W-1:0] sec_q,
  input logic [31:0]      ns_q,
  input logic [31:0]      bp_q,
  input logic             time_wr,
  input logic             roll,
  input logic             irq_req,
  input logic             en_q,
  input logic             ack_hit,
  input logic             disarm,
  input logic             expire,
  input logic [CD_W-1:0]  cd_q,
  input logic             cd_wr
);
  AST_NS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_q < NS_PER_SEC && bp_q < NS_PER_SEC && !time_wr) |=> ns_q < NS_PER_SEC); // R3

  AST_NS_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!time_wr && !roll) |=> (ns_q == $past(ns_q) + $past(bp_q)) && (sec_q == $past(sec_q))); // R3

  AST_SEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> sec_q == $past(sec_q) + SEC_W'(1)); // R4

  AST_EXPIRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq_req); // R7

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && en_q && !ack_hit && !disarm) |=> irq_req); // R9

  AST_IRQ_OFF_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !irq_req); // R10

  AST_CD_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_q != '0 && !cd_wr) |=> cd_q == $past(cd_q) - CD_W'(1)); // R11

  AST_CD_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_q == '0 && !cd_wr) |=> cd_q == '0); // R11
endmodule

bind ptmr_top ptmr_chk #(.SEC_W(SEC_W), .CD_W(CD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_q(sec_q), .ns_q(ns_q), .bp_q(bp_q),
  .time_wr(time_wr), .roll(roll), .irq_req(irq_req), .en_q(en_q),
  .ack_hit(ack_hit), .disarm(disarm), .expire(expire), .cd_q(cd_q), .cd_wr(cd_wr)
);

// File: tb/tb_ptmr_top.sv
module tb_ptmr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req;
  logic [7:0]  irq_num;
  logic        irq_ack = 1'b0;
  logic [7:0]  irq_ack_num = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int unsigned cyc = 0;

  ptmr_top dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_num(irq_num),
    .irq_ack(irq_ack), .irq_ack_num(irq_ack_num)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural register model built from the requirements
  logic [31:0] m_ctrl, m_thr, m_bp, m_ns, m_shi, m_sns, m_exp;
  logic [63:0] m_sec;
  logic [11:0] m_cd;

  function automatic logic [31:0] cd_next_model(input logic [31:0] v);
    return (v == 0) ? 32'd0 : v - 1;
  endfunction

  always @(posedge clk) begin
    logic [63:0] t;
    logic        tw;
    if (!rst_n) begin
      m_ctrl = 0; m_thr = 0; m_bp = 32'd4; m_ns = 0; m_shi = 0; m_sns = 0;
      m_exp = 0; m_sec = 0; m_cd = 0;
    end else begin
      if (bus_rd) begin
        case (bus_addr)
          8'h00: m_exp = m_ctrl;
          8'h10: m_exp = m_thr;
          8'h14: m_exp = {20'd0, m_cd};
          8'h18: m_exp = m_bp;
          8'h20: m_exp = m_shi;
          8'h24: begin m_exp = m_sec[31:0]; m_shi = m_sec[63:32]; m_sns = m_ns; end
          8'h28: m_exp = m_sns;
          default: m_exp = 0;
        endcase
      end
      tw = bus_wr && (bus_addr == 8'h20 || bus_addr == 8'h24 || bus_addr == 8'h28);
      if (!tw) begin
        t = {32'd0, m_ns} + {32'd0, m_bp};
        if (t > 64'd999_999_999) begin
          t = t - 64'd1_000_000_000;
          m_sec = m_sec + 1;
        end
        m_ns = t[31:0];
      end
      m_cd = 12'(cd_next_model({20'd0, m_cd}));
      if (bus_wr) begin
        case (bus_addr)
          8'h00: m_ctrl = bus_wdata & 32'h0000_FFF1;
          8'h10: m_thr = bus_wdata;
          8'h14: m_cd = bus_wdata[11:0];
          8'h18: m_bp = bus_wdata;
          8'h20: m_sec[63:32] = bus_wdata;
          8'h24: m_sec[31:0] = bus_wdata;
          8'h28: m_ns = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, bus_rdata, m_exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(output int k);
    k = 0;
    while (!irq_req && k < 100) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int k;
    int unsigned c0;
    int highs;
    int unsigned seed;
    seed = $urandom(32'd20161011);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq_req", {31'd0, irq_req}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    rd(8'h18, "R1 bus period");
    chk("R1 bus period value", bus_rdata, 32'd4);
    rd(8'h00, "R1 ctrl");
    chk("R1 ctrl value", bus_rdata, 32'd0);
    rd(8'h10, "R1 throttle");
    rd(8'h14, "R1 countdown");

    // R2: readback and masking
    wr(8'h00, 32'hFFFF_FFFE);
    rd(8'h00, "R2 ctrl mask");
    chk("R2 ctrl mask value", bus_rdata, 32'h0000_FFF0);
    wr(8'h00, 32'd0);
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h10, "R2 throttle");
    chk("R2 throttle value", bus_rdata, 32'hDEAD_BEEF);
    rd(8'h04, "R2 unmapped");
    chk("R2 unmapped value", bus_rdata, 32'd0);

    // R3 / R6: nanosecond advance and second carry
    wr(8'h18, 32'd300_000_000);
    wr(8'h20, 32'd0);
    wr(8'h24, 32'd0);
    wr(8'h28, 32'd0);
    idle(3);
    rd(8'h24, "R3 sec lo");
    rd(8'h28, "R3 ns snap");
    chk("R3 ns 900M", bus_rdata, 32'd900_000_000);
    rd(8'h24, "R3 sec lo after carry");
    chk("R3 sec lo one", bus_rdata, 32'd1);
    rd(8'h28, "R3 ns snap 2");
    chk("R3 ns wrapped", bus_rdata, 32'd500_000_000);

    // R6: load with no advance in the write cycle
    wr(8'h28, 32'd123);
    rd(8'h24, "R6 sec lo");
    rd(8'h28, "R6 ns");
    chk("R6 ns loaded", bus_rdata, 32'd123);

    // R4: carry into the high word
    wr(8'h18, 32'd4);
    wr(8'h20, 32'd5);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h28, 32'd999_999_995);
    idle(3);
    rd(8'h24, "R4 sec lo");
    chk("R4 sec lo wrapped", bus_rdata, 32'd0);
    rd(8'h20, "R4 sec hi");
    chk("R4 sec hi carried", bus_rdata, 32'd6);
    // R5: snapshot stable across later reads
    rd(8'h28, "R5 ns snap a");
    k = int'(bus_rdata);
    idle(5);
    rd(8'h28, "R5 ns snap b");
    chk("R5 snapshot stable", bus_rdata, 32'(k));

    // R11: countdown
    wr(8'h14, 32'd10);
    rd(8'h14, "R11 cd running");
    idle(20);
    rd(8'h14, "R11 cd at zero");
    chk("R11 cd zero value", bus_rdata, 32'd0);
    wr(8'h14, 32'h0000_1ABC);
    rd(8'h14, "R11 cd truncated");
    chk("R11 cd 12-bit load", bus_rdata, 32'h0000_0ABC);

    // R7 / R8 / R9 / R10: periodic interrupt
    wr(8'h10, 32'd8);
    wr(8'h00, 32'h0000_41A1);
    c0 = cyc;
    chk("R8 irq_num", {24'd0, irq_num}, 32'h69);
    wait_irq(k);
    chk("R7 first period", cyc - c0, 32'd8);
    idle(3);
    chk("R9 held", {31'd0, irq_req}, 32'd1);
    irq_ack = 1'b1; irq_ack_num = 8'h41;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R9 wrong number ignored", {31'd0, irq_req}, 32'd1);
    irq_ack = 1'b1; irq_ack_num = 8'h69;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R9 matching ack clears", {31'd0, irq_req}, 32'd0);
    wait_irq(k);
    chk("R7 second period", cyc - c0, 32'd16);
    wr(8'h00, 32'h0000_41A0);
    chk("R10 dropped on disable", {31'd0, irq_req}, 32'd0);
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq_req) highs++;
    end
    chk("R10 stays stopped", 32'(highs), 32'd0);

    // R7 throttle 0 and R9 expiry beats ack
    wr(8'h10, 32'd0);
    wr(8'h00, 32'h0000_41A1);
    @(negedge clk);
    chk("R7 throttle zero", {31'd0, irq_req}, 32'd1);
    irq_ack = 1'b1; irq_ack_num = 8'h69;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 expiry wins over ack", {31'd0, irq_req}, 32'd1);
    end
    irq_ack = 1'b0;
    wr(8'h00, 32'd0);
    chk("R10 off again", {31'd0, irq_req}, 32'd0);

    // Random mix checked against the model
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      op = $urandom % 10;
      case (op)
        0: wr(8'h18, 32'd1 + ($urandom % 32'd999_999_998));
        1: wr(8'h14, $urandom);
        2: wr(8'h28, $urandom % 32'd1_000_000_000);
        3: wr(8'h24, $urandom);
        4: wr(8'h00, $urandom & 32'hFFFF_FFFE);
        5: wr(8'h10, $urandom);
        6: begin rd(8'h24, "R5 rand lo"); rd(8'h20, "R5 rand hi"); rd(8'h28, "R3 rand ns"); end
        7: rd(8'h14, "R11 rand cd");
        8: rd(8'h00, "R2 rand ctrl");
        default: idle(1 + ($urandom % 4));
      endcase
    end
    rd(8'h18, "R2 final bp");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule